// File: doc/BRIEF.md
# HDLC Frame Transmitter with Automatic Link Control

This block turns a stream of bytes into a bit-oriented synchronous frame on a single serial line. Bytes enter a four-entry queue through a valid/ready write port, with a marker on the final byte of each frame. When the serializer is idle and a byte is waiting, it starts the frame without further command. It sends an opening flag, presets its check sequence and shifts the payload out least significant bit first. A zero is inserted after any five consecutive ones. It then appends the inverted 16-bit check sequence and ends with a closing flag. One bit leaves per pulse of the bit-clock enable, so an external rate generator sets the line speed.

The line is either driven directly or NRZI-coded, and between frames it carries either continuous ones or back-to-back flags. An active-low request-to-send output follows the request input, but it is held asserted until the final bit of a closing flag (or abort) is on the line. If the queue runs dry inside a frame that has no end marker, the block sends an abort of ones. It also raises an underrun status, which clears by itself when the next frame starts.

The controlling state machine has six states. IDLE sends idle fill. OPEN sends the opening flag. DATA sends payload bits. FCS sends the check sequence. CLOSE sends the closing flag. ABORT sends the abort ones. Its transitions are: start (IDLE to OPEN, queue not empty and, with flag fill, at a flag boundary); first-load (OPEN to DATA after flag bit 7, popping a byte); next-byte (DATA to DATA, popping another byte); end-of-data (DATA to FCS, after a byte carrying the end marker); starve (DATA to ABORT, queue empty without an end marker); fcs-done (FCS to CLOSE after 16 check bits); close-done (CLOSE to IDLE after flag bit 7); abort-done (ABORT to IDLE after the abort run).

Top module: `hdlc_frame_tx`

## Requirements
- R1: With the transmitter idle and a byte queued, the pattern 01111110 goes out with no command. The payload bytes follow least significant bit first, then the check sequence, then a closing 01111110. Each bit_en pulse sends exactly one bit; with mark fill the frame starts at the next pulse.
- R2: After five consecutive 1 bits within payload or check sequence a 0 is inserted; a pending insertion after the last check bit precedes the closing flag; flag bits are never followed by an inserted 0.
- R3: The check sequence is the 16-bit x^16+x^12+x^5+1 code, processed bit-reflected (0x8408), preset to 0xFFFF when the frame starts, and sent inverted, bit 0 first (the nine ASCII bytes "123456789" give a sent value of 0x906E).
- R4: The queue holds 4 bytes; wr_ready is low exactly when 4 are held; wr_req is high exactly when the number of free entries is at least cfg_req_lvl.
- R5: If the queue is empty after a byte without the end marker, 8 ones follow that byte, tx_underrun goes high and the block returns to idle; tx_underrun returns low when the next frame starts.
- R6: rts_n is low one clock after rts_req goes high; when rts_req falls during a frame, rts_n rises on the clock after the final closing-flag bit is put on txd, not earlier.
- R7: With cfg_mark_idle high the idle line carries 1s; with it low the idle line carries flags back to back and a frame begins on a flag boundary.
- R8: With cfg_nrzi high, txd toggles for a 0 bit and holds for a 1 bit; with cfg_nrzi and cfg_mark_idle both high, txd is held at 1 while idle.
- R9: txd changes only on the clock edge where bit_en is high; with bit_en low the line and the frame progress are frozen.
- R10: After reset txd=1, rts_n=1, wr_ready=1, wr_req=1 and tx_underrun=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nrzi | input | 1 | 1 selects NRZI line coding |
| cfg_mark_idle | input | 1 | 1 selects ones between frames, 0 selects flags |
| cfg_req_lvl | input | 3 | Free-entry threshold for wr_req |
| wr_valid | input | 1 | Byte offered on the write port |
| wr_ready | output | 1 | Queue can accept a byte |
| wr_data | input | 8 | Byte to send |
| wr_eof | input | 1 | Byte is the last of its frame |
| wr_req | output | 1 | Free entries at or above threshold |
| bit_en | input | 1 | One-cycle pulse per serial bit time |
| rts_req | input | 1 | Request to assert request-to-send |
| txd | output | 1 | Serial line output |
| rts_n | output | 1 | Active-low request-to-send |
| tx_underrun | output | 1 | Frame ended by queue starvation |

## Verification
The assertions watch, on every cycle, that txd moves only after a bit_en pulse and stays high at NRZI mark fill. They also cover the consecutive-ones count never passing five, request-to-send staying asserted inside a frame, the underrun status rising only with an abort, and the queue never underflowing or exceeding its depth. Only the bench scenarios can show that the serial stream is right bit for bit. That means the check sequence value, the placement of inserted zeros across byte and field boundaries, and the NRZI decode. They also cover the exact cycle on which request-to-send is released and the fill-threshold behaviour at every occupancy.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_DATA,
        ST_FCS,
        ST_CLOSE,
        ST_ABORT
    } tx_state_e;

    typedef struct packed {
        logic       eof;
        logic [7:0] data;
    } tx_entry_t;

    localparam logic [7:0] FLAG_PAT = 8'h7E;

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  tx_entry_t        din,
    input  logic             pop,
    output tx_entry_t        dout,
    output logic             empty,
    output logic             full,
    input  logic [LVL_W-1:0] lvl,
    output logic             lvl_ok
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    tx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wp_q, rp_q;
    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   free_cnt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                wp_q <= bump(wp_q);
            end
            if (pop) begin
                rp_q <= bump(rp_q);
            end
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign dout     = mem[rp_q];
    assign empty    = (cnt_q == '0);
    assign full     = (cnt_q == CW'(DEPTH));
    assign free_cnt = CW'(DEPTH) - cnt_q;
    assign lvl_ok   = (32'(free_cnt) >= 32'(lvl));

    // R4
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
    parameter int                 W    = 16,
    parameter logic [W-1:0]       POLY = 16'h8408
) (
    input  logic clk,
    input  logic rst_n,
    input  logic preset,
    input  logic upd,
    input  logic din,
    input  logic shift,
    output logic fcs_bit
);
    logic [W-1:0] crc_q;
    logic         fb;

    assign fb = crc_q[0] ^ din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (preset) begin
            crc_q <= '1;
        end else if (upd) begin
            crc_q <= (crc_q >> 1) ^ (fb ? POLY : '0);
        end else if (shift) begin
            crc_q <= {1'b1, crc_q[W-1:1]};
        end
    end

    assign fcs_bit = ~crc_q[0];

endmodule

// File: rtl/hdlc_tx_line.sv
module hdlc_tx_line (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic raw,
    input  logic nrzi,
    input  logic hold_hi,
    output logic txd
);
    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b1;
        end else if (bit_en) begin
            if (hold_hi) begin
                lvl_q <= 1'b1;
            end else if (!nrzi) begin
                lvl_q <= raw;
            end else if (!raw) begin
                lvl_q <= ~lvl_q;
            end
        end
    end

    assign txd = lvl_q;

    // R9
    txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> $stable(txd));

    // R8
    mark_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && hold_hi) |=> txd);

endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx
    import hdlc_tx_pkg::*;
#(
    parameter int           FIFO_DEPTH = 4,
    parameter int           LVL_W      = 3,
    parameter int           ABORT_LEN  = 8,
    parameter int           CRC_W      = 16,
    parameter logic [15:0]  CRC_POLY   = 16'h8408
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_nrzi,
    input  logic             cfg_mark_idle,
    input  logic [LVL_W-1:0] cfg_req_lvl,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    input  logic             wr_eof,
    output logic             wr_req,
    input  logic             bit_en,
    input  logic             rts_req,
    output logic             txd,
    output logic             rts_n,
    output logic             tx_underrun
);
    localparam int CNT_MAX = (CRC_W > ABORT_LEN) ? CRC_W : ABORT_LEN;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    tx_state_e          st_q, st_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [2:0]         icnt_q, icnt_d;
    logic [2:0]         ones_q, ones_d;
    logic [7:0]         sh_q, sh_d;
    logic               last_q, last_d;
    logic               undr_q, undr_d;
    logic               rts_n_q, rts_n_d;

    tx_entry_t          wr_ent, head;
    logic               q_empty, q_full, push, pop;
    logic               crc_preset, crc_upd, crc_shift, fcs_bit;
    logic               raw, hold_hi, start, stuff;

    assign wr_ent   = '{eof: wr_eof, data: wr_data};
    assign wr_ready = !q_full;
    assign push     = wr_valid && !q_full;

    hdlc_tx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .LVL_W (LVL_W)
    ) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .din    (wr_ent),
        .pop    (pop),
        .dout   (head),
        .empty  (q_empty),
        .full   (q_full),
        .lvl    (cfg_req_lvl),
        .lvl_ok (wr_req)
    );

    hdlc_tx_crc #(
        .W    (CRC_W),
        .POLY (CRC_POLY[CRC_W-1:0])
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .preset  (crc_preset),
        .upd     (crc_upd),
        .din     (sh_q[0]),
        .shift   (crc_shift),
        .fcs_bit (fcs_bit)
    );

    hdlc_tx_line u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .raw     (raw),
        .nrzi    (cfg_nrzi),
        .hold_hi (hold_hi),
        .txd     (txd)
    );

    assign start = !q_empty && (cfg_mark_idle || (icnt_q == 3'd0));
    assign stuff = (ones_q == 3'd5);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            icnt_q  <= '0;
            ones_q  <= '0;
            sh_q    <= '0;
            last_q  <= 1'b0;
            undr_q  <= 1'b0;
            rts_n_q <= 1'b1;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            icnt_q  <= icnt_d;
            ones_q  <= ones_d;
            sh_q    <= sh_d;
            last_q  <= last_d;
            undr_q  <= undr_d;
            rts_n_q <= rts_n_d;
        end
    end

    // transitions
    always_comb begin
        st_d       = st_q;
        cnt_d      = cnt_q;
        icnt_d     = icnt_q;
        ones_d     = ones_q;
        sh_d       = sh_q;
        last_d     = last_q;
        undr_d     = undr_q;
        pop        = 1'b0;
        crc_preset = 1'b0;
        crc_upd    = 1'b0;
        crc_shift  = 1'b0;
        if (bit_en) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_d       = ST_OPEN;
                        cnt_d      = CNT_W'(1);
                        icnt_d     = '0;
                        crc_preset = 1'b1;
                        undr_d     = 1'b0;
                    end else begin
                        icnt_d = cfg_mark_idle ? 3'd0 : icnt_q + 3'd1;
                    end
                end
                ST_OPEN: begin
                    if (cnt_q == CNT_W'(7)) begin
                        pop    = 1'b1;
                        sh_d   = head.data;
                        last_d = head.eof;
                        cnt_d  = '0;
                        ones_d = '0;
                        st_d   = ST_DATA;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (stuff) begin
                        ones_d = '0;
                    end else begin
                        crc_upd = 1'b1;
                        ones_d  = sh_q[0] ? ones_q + 3'd1 : 3'd0;
                        sh_d    = {1'b0, sh_q[7:1]};
                        if (cnt_q == CNT_W'(7)) begin
                            cnt_d = '0;
                            if (last_q) begin
                                st_d = ST_FCS;
                            end else if (!q_empty) begin
                                pop    = 1'b1;
                                sh_d   = head.data;
                                last_d = head.eof;
                            end else begin
                                st_d   = ST_ABORT;
                                undr_d = 1'b1;
                            end
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_FCS: begin
                    if (stuff) begin
                        ones_d = '0;
                    end else begin
                        crc_shift = 1'b1;
                        ones_d    = fcs_bit ? ones_q + 3'd1 : 3'd0;
                        if (cnt_q == CNT_W'(CRC_W - 1)) begin
                            cnt_d = '0;
                            st_d  = ST_CLOSE;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_CLOSE: begin
                    ones_d = '0;
                    if (!stuff) begin
                        if (cnt_q == CNT_W'(7)) begin
                            cnt_d  = '0;
                            icnt_d = '0;
                            st_d   = ST_IDLE;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_ABORT: begin
                    if (cnt_q == CNT_W'(ABORT_LEN - 1)) begin
                        cnt_d  = '0;
                        icnt_d = '0;
                        st_d   = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
        rts_n_d = !(rts_req || (!rts_n_q && (st_q != ST_IDLE)));
    end

    // outputs
    always_comb begin
        raw     = 1'b1;
        hold_hi = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                raw     = start ? 1'b0 : (cfg_mark_idle ? 1'b1 : FLAG_PAT[icnt_q]);
                hold_hi = cfg_mark_idle && cfg_nrzi && !start;
            end
            ST_OPEN:  raw = FLAG_PAT[cnt_q[2:0]];
            ST_DATA:  raw = stuff ? 1'b0 : sh_q[0];
            ST_FCS:   raw = stuff ? 1'b0 : fcs_bit;
            ST_CLOSE: raw = stuff ? 1'b0 : FLAG_PAT[cnt_q[2:0]];
            ST_ABORT: raw = 1'b1;
            default:  raw = 1'b1;
        endcase
    end

    assign rts_n       = rts_n_q;
    assign tx_underrun = undr_q;

    // R1
    open_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && bit_en && !q_empty && cfg_mark_idle) |=> (st_q == ST_OPEN));

    // R2
    ones_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= 3'd5);

    // R6
    rts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts_n && st_q != ST_IDLE) |=> !rts_n);

    // R5
    undr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_underrun) |-> (st_q == ST_ABORT));

endmodule

// File: tb/sim_hdlc_frame_tx.sv
`timescale 1ns/1ps
module sim_hdlc_frame_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_nrzi = 1'b0;
    logic       cfg_mark_idle = 1'b1;
    logic [2:0] cfg_req_lvl = 3'd1;
    logic       wr_valid = 1'b0;
    logic       wr_ready;
    logic [7:0] wr_data = 8'h00;
    logic       wr_eof = 1'b0;
    logic       wr_req;
    logic       bit_en = 1'b0;
    logic       rts_req = 1'b0;
    logic       txd, rts_n, tx_underrun;

    int  total = 0;
    int  bad   = 0;
    bit  gate  = 1'b1;
    bit  cap_lvl [4096];
    bit  cap_raw [4096];
    int  cap_n   = 0;
    bit  prev_lvl = 1'b1;
    bit  rts_prev = 1'b1;
    int  rise_at  = -1;
    bit  exp_b [1024];
    int  exp_n = 0;
    logic [7:0] fr [16];

    always #2.5 clk = ~clk;

    hdlc_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .cfg_nrzi(cfg_nrzi), .cfg_mark_idle(cfg_mark_idle),
        .cfg_req_lvl(cfg_req_lvl), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .wr_eof(wr_eof), .wr_req(wr_req), .bit_en(bit_en),
        .rts_req(rts_req), .txd(txd), .rts_n(rts_n), .tx_underrun(tx_underrun)
    );

    // bit clock and line capture: one pulse every 4 clocks
    initial begin
        forever begin
            @(negedge clk);
            bit_en = gate;
            @(negedge clk);
            if (bit_en && cap_n < 4096) begin
                cap_lvl[cap_n] = txd;
                cap_raw[cap_n] = cfg_nrzi ? (txd == prev_lvl) : txd;
                cap_n = cap_n + 1;
            end
            prev_lvl = txd;
            bit_en = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    end

    always @(negedge clk) begin
        if (rts_n && !rts_prev) rise_at = cap_n;
        rts_prev = rts_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_bit(input bit b);
        exp_b[exp_n] = b;
        exp_n++;
    endtask

    task automatic push_flag();
        for (int i = 0; i < 8; i++) push_bit((i != 0) && (i != 7));
    endtask

    function automatic logic [15:0] fcs_step(input logic [15:0] c, input bit d);
        logic [15:0] r;
        r = c >> 1;
        if (c[0] ^ d) r = r ^ 16'h8408;
        return r;
    endfunction

    // expected raw bit stream for fr[0..n-1]
    task automatic build(input int n, input bit abort_it);
        int ones;
        logic [15:0] c;
        bit b;
        exp_n = 0;
        ones  = 0;
        c     = 16'hFFFF;
        push_flag();
        for (int j = 0; j < n; j++) begin
            for (int i = 0; i < 8; i++) begin
                b = fr[j][i];
                if (ones == 5) begin push_bit(1'b0); ones = 0; end
                push_bit(b);
                ones = b ? ones + 1 : 0;
                c = fcs_step(c, b);
            end
        end
        if (abort_it) begin
            for (int i = 0; i < 8; i++) push_bit(1'b1);
        end else begin
            c = ~c;
            for (int i = 0; i < 16; i++) begin
                b = c[i];
                if (ones == 5) begin push_bit(1'b0); ones = 0; end
                push_bit(b);
                ones = b ? ones + 1 : 0;
            end
            if (ones == 5) push_bit(1'b0);
            push_flag();
        end
    endtask

    function automatic int find_exp();
        for (int s = 0; s + exp_n <= cap_n; s++) begin
            bit m;
            m = 1'b1;
            for (int k = 0; k < exp_n; k++) begin
                if (cap_raw[s + k] != exp_b[k]) begin m = 1'b0; break; end
            end
            if (m) return s + exp_n - 1;
        end
        return -1;
    endfunction

    task automatic put(input logic [7:0] d, input bit eof);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        wr_eof   = eof;
        while (!wr_ready) @(negedge clk);
        @(posedge clk);
        #1 wr_valid = 1'b0;
    endtask

    task automatic clear_cap();
        @(posedge clk);
        cap_n = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // sends fr[0..n-1]; returns index of last expected bit, or -1
    task automatic run_frame(input int n, input bit abort_it, input int slack,
                             input bit pause, input bit drop_rts, output int e);
        build(n, abort_it);
        clear_cap();
        for (int j = 0; j < n; j++) put(fr[j], (j == n - 1) && !abort_it);
        if (pause) begin
            logic hold;
            int   moved;
            wait (cap_n >= 14);
            @(negedge clk);
            gate = 1'b0;
            @(negedge clk);
            @(negedge clk);
            hold  = txd;
            moved = 0;
            repeat (24) begin
                @(negedge clk);
                if (txd !== hold) moved++;
            end
            // R9: frozen line with bit_en low
            chk(moved == 0, "R9 line frozen without bit_en", moved, 0);
            gate = 1'b1;
        end
        if (drop_rts) begin
            wait (cap_n >= 20);
            @(negedge clk);
            rts_req = 1'b0;
            rise_at = -1;
            repeat (3) @(negedge clk);
            // R6: still asserted mid-frame
            chk(rts_n == 1'b0, "R6 rts held during frame", rts_n, 0);
        end
        wait (cap_n >= exp_n + slack);
        e = find_exp();
    endtask

    initial begin
        int e;
        logic [15:0] c;
        logic [7:0] s9 [9];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(txd == 1'b1, "R10 txd", txd, 1);
        chk(rts_n == 1'b1, "R10 rts_n", rts_n, 1);
        chk(wr_ready == 1'b1, "R10 wr_ready", wr_ready, 1);
        chk(wr_req == 1'b1, "R10 wr_req", wr_req, 1);
        chk(tx_underrun == 1'b0, "R10 tx_underrun", tx_underrun, 0);

        // R3: bench check sequence model against the known value
        for (int i = 0; i < 9; i++) s9[i] = 8'h31 + 8'(i);
        c = 16'hFFFF;
        for (int i = 0; i < 9; i++)
            for (int k = 0; k < 8; k++) c = fcs_step(c, s9[i][k]);
        chk(~c == 16'h906E, "R3 check value", int'(~c), 16'h906E);

        // R4: occupancy x threshold sweep with the serializer frozen
        gate = 1'b0;
        repeat (8) @(negedge clk);
        for (int k = 0; k <= 4; k++) begin
            for (int lv = 0; lv <= 4; lv++) begin
                cfg_req_lvl = 3'(lv);
                @(negedge clk);
                chk(wr_req == ((4 - k) >= lv), "R4 wr_req level", wr_req, int'((4 - k) >= lv));
            end
            chk(wr_ready == (k < 4), "R4 wr_ready", wr_ready, int'(k < 4));
            if (k < 4) put(8'hA0 + 8'(k), 1'b1);
        end
        // R9: nothing leaves without bit_en
        chk(txd == 1'b1, "R9 txd idle while frozen", txd, 1);
        cfg_req_lvl = 3'd1;
        do_reset();
        gate = 1'b1;

        // R7: mark fill is all ones
        clear_cap();
        wait (cap_n >= 12);
        e = 0;
        for (int i = 0; i < 12; i++) if (!cap_lvl[i]) e++;
        chk(e == 0, "R7 mark fill ones", e, 0);

        // R1 R2 R3: every single-byte frame
        for (int v = 0; v < 256; v++) begin
            fr[0] = 8'(v);
            run_frame(1, 1'b0, 20, 1'b0, 1'b0, e);
            chk(e >= 0, $sformatf("R1/R2/R3 one-byte frame %0d", v), e, 0);
        end

        // R1 R2 R3 R8: multi-byte frames, plain and NRZI
        for (int nz = 0; nz < 2; nz++) begin
            cfg_nrzi = nz[0];
            for (int n = 2; n <= 6; n++) begin
                for (int j = 0; j < n; j++)
                    fr[j] = (j % 3 == 0) ? 8'hFF : 8'((n * 53 + j * 29) & 255);
                run_frame(n, 1'b0, 20, 1'b0, 1'b0, e);
                chk(e >= 0, $sformatf("R1/R2/R3/R8 frame len %0d nrzi %0d", n, nz), e, 0);
            end
        end

        // R8: NRZI with mark fill holds the line high
        cfg_nrzi = 1'b1;
        clear_cap();
        wait (cap_n >= 16);
        e = 0;
        for (int i = 0; i < 16; i++) if (!cap_lvl[i]) e++;
        chk(e == 0, "R8 NRZI mark fill high", e, 0);

        // R9: pause mid-frame, frame still intact
        for (int j = 0; j < 4; j++) fr[j] = 8'h5A ^ 8'(j * 17);
        run_frame(4, 1'b0, 20, 1'b1, 1'b0, e);
        chk(e >= 0, "R9 frame across pause", e, 0);

        // R5: starvation abort and self-clearing status
        cfg_nrzi = 1'b0;
        fr[0] = 8'hFF;
        fr[1] = 8'h3C;
        run_frame(2, 1'b1, 20, 1'b0, 1'b0, e);
        chk(e >= 0, "R5 abort pattern", e, 0);
        chk(tx_underrun == 1'b1, "R5 underrun set", tx_underrun, 1);
        fr[0] = 8'h81;
        run_frame(1, 1'b0, 20, 1'b0, 1'b0, e);
        chk(e >= 0, "R5 frame after abort", e, 0);
        chk(tx_underrun == 1'b0, "R5 underrun cleared by new frame", tx_underrun, 0);

        // R6: request-to-send
        rts_req = 1'b1;
        repeat (2) @(negedge clk);
        chk(rts_n == 1'b0, "R6 rts asserted", rts_n, 0);
        fr[0] = 8'hC3; fr[1] = 8'h7E; fr[2] = 8'h1F;
        run_frame(3, 1'b0, 20, 1'b0, 1'b1, e);
        chk(e >= 0, "R6 frame", e, 0);
        chk(rise_at == e + 1, "R6 release after closing flag", rise_at, e + 1);

        // R7: flag fill, back to back
        cfg_mark_idle = 1'b0;
        clear_cap();
        wait (cap_n >= 48);
        exp_n = 0;
        push_flag(); push_flag(); push_flag();
        e = find_exp();
        chk(e >= 0, "R7 back-to-back flags", e, 0);

        // R7 R8: frames under flag fill
        for (int nz = 0; nz < 2; nz++) begin
            cfg_nrzi = nz[0];
            fr[0] = 8'hFC; fr[1] = 8'h3F; fr[2] = 8'h00;
            run_frame(3, 1'b0, 32, 1'b0, 1'b0, e);
            chk(e >= 0, $sformatf("R7/R8 frame in flag fill nrzi %0d", nz), e, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule